// File: doc/BRIEF.md
# Dual-lane interleaved Montgomery multiplier

The block computes two Montgomery modular products at the same time. Both share one multiplicand and one modulus, which are captured in parallel on a start pulse. Each lane has its own multiplier, which enters on a single serial pin, least significant bit first. The bits of the two lanes alternate cycle by cycle: lane 0 comes first, then lane 1, then the next bit of lane 0, and so on. Each lane runs the iteration P(i+1) = (P(i) + q(i)·N)/2 + b(i)·A for i = 0 to n, with P(0) = 0. The quotient bit q(i) is the least significant bit of P(i).

Internally the partial sums are kept in carry-save form. Each iteration is split into two full-adder rows. The first row adds the gated modulus and the second row adds the gated multiplicand. The two lanes occupy the two rows in turn, so both rows work on every cycle and no cycle is idle. After the last iteration each lane's carry-save value is resolved by a bit-serial adder. The results leave on one serial pin in the same alternating order, each bit marked by a valid flag and a lane flag.

The exponentiation sequence, key handling and conversion into and out of the Montgomery domain are outside the block.

Top module: `ilv_mont_mul`

## Requirements
- R1: Each lane's result equals the exact value of the recurrence P(i+1) = (P(i) + q(i)·N)/2 + b(i)·A, run for i = 0..n with P(0) = 0, q(i) = P(i) mod 2 and b(n) = 0, where n is WIDTH.
- R2: Each lane's result R satisfies R·2^n ≡ A·B (mod N).
- R3: When N is odd, 4N ≤ 2^n and A, B < 2N, each result is less than 2N.
- R4: If start is high in the cycle ending at edge E0, b_in is sampled at edge E0+1+k for k = 0..2n+1. Even k carries lane 0 bit k/2 and odd k carries lane 1 bit (k-1)/2. The samples k = 2n and k = 2n+1 have no effect on the results.
- R5: res_valid is high in exactly 2n consecutive cycles, namely the cycles following edges E0+2n+4 through E0+4n+3. Lane 0 bit j appears after edge E0+2n+4+2j and lane 1 bit j one cycle later, least significant bit first.
- R6: res_lane is 0 while a lane 0 bit is shown and 1 while a lane 1 bit is shown.
- R7: After reset, and whenever res_valid is low, res_bit, res_valid and res_lane are all 0.
- R8: A start pulse during a run abandons that run: res_valid goes low on the next cycle and the new run then behaves as in R4 and R5.
- R9: a_in and m_in are captured only at the start edge; changing them later does not affect the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures a_in and m_in and begins a run |
| a_in | input | WIDTH | Shared multiplicand A |
| m_in | input | WIDTH | Odd modulus N |
| b_in | input | 1 | Interleaved serial multiplier bits, lane 0 first |
| res_bit | output | 1 | Interleaved serial result bit |
| res_valid | output | 1 | res_bit carries a result bit |
| res_lane | output | 1 | Lane of the current result bit |

## Verification
The case hardest to reach from the ports is the one where the two lanes hold very different values, so that any leak between the interleaved rows would corrupt a result. The bench therefore pairs each lane 0 multiplier with a lane 1 multiplier drawn from the opposite end of the range. It sweeps these pairs densely over several moduli up to the largest value the bound allows. The other rare cases are also driven on purpose: ones on the two ignored input slots, operand inputs flipped right after start, and a restart while results are still leaving.

// File: rtl/ilv_mont_pkg.sv
package ilv_mont_pkg;
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/ilv_mont_cell.sv
module ilv_mont_cell
  import ilv_mont_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic v,
  input  logic g,
  output logic s,
  output logic c
);
  logic z;
  assign z = g & v;
  assign s = fa_sum(x, y, z);
  assign c = fa_carry(x, y, z);
endmodule

// File: rtl/ilv_mont_row.sv
module ilv_mont_row #(
  parameter int W = 10
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] v,
  input  logic         g,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  for (genvar j = 0; j < W; j++) begin : g_cell
    ilv_mont_cell u_cell (
      .x(x[j]), .y(y[j]), .v(v[j]), .g(g), .s(s[j]), .c(c[j])
    );
  end
endmodule

// File: rtl/ilv_mont_ctrl.sv
module ilv_mont_ctrl #(
  parameter int NB = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic upd,
  output logic bgate,
  output logic load,
  output logic emit,
  output logic lane
);
  localparam int LAST = 4 * NB + 2;
  localparam int CW   = $clog2(LAST + 2);
  localparam logic [CW-1:0] K_BEND  = CW'(2 * NB);
  localparam logic [CW-1:0] K_UEND  = CW'(2 * NB + 2);
  localparam logic [CW-1:0] K_OBEG  = CW'(2 * NB + 3);
  localparam logic [CW-1:0] K_LAST  = CW'(LAST);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (cnt == K_LAST) run <= 1'b0;
    end
  end

  assign upd   = run && (cnt <= K_UEND);
  assign bgate = cnt < K_BEND;
  assign load  = run && ((cnt == K_UEND) || (cnt == K_OBEG));
  assign emit  = run && (cnt >= K_OBEG) && (cnt <= K_LAST);
  assign lane  = ~cnt[0];
endmodule

// File: rtl/ilv_mont_serout.sv
module ilv_mont_serout
  import ilv_mont_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_c,
  output logic         bit_o
);
  logic [W-1:0] fs, bs;
  logic [W:0]   fc, bc;
  logic         fcy, bcy;

  assign bit_o = fa_sum(fs[0], fc[0], fcy);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs  <= '0;
      fc  <= '0;
      fcy <= 1'b0;
      bs  <= '0;
      bc  <= '0;
      bcy <= 1'b0;
    end else if (en) begin
      if (load) begin
        fs  <= in_s;
        fc  <= {in_c, 1'b0};
        fcy <= 1'b0;
      end else begin
        fs  <= bs;
        fc  <= bc;
        fcy <= bcy;
      end
      bs  <= fs >> 1;
      bc  <= fc >> 1;
      bcy <= fa_carry(fs[0], fc[0], fcy);
    end
  end
endmodule

// File: rtl/ilv_mont_mul.sv
module ilv_mont_mul #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] m_in,
  input  logic             b_in,
  output logic             res_bit,
  output logic             res_valid,
  output logic             res_lane
);
  localparam int W = WIDTH + 2;

  logic [W-1:0] a_r, m_r;
  logic [W-1:0] cur_s, cur_c, mid_s, mid_c;
  logic [W-1:0] l1_s, l1_c, l2_s, l2_c;
  logic         b_reg;
  logic         upd, bgate, load, emit, lane, ser_bit;

  ilv_mont_ctrl #(.NB(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .upd(upd), .bgate(bgate), .load(load), .emit(emit), .lane(lane)
  );

  // first row: add the modulus gated by the quotient bit of the lane entering
  ilv_mont_row #(.W(W)) u_row_mod (
    .x(cur_s), .y(cur_c << 1), .v(m_r), .g(cur_s[0]),
    .s(l1_s), .c(l1_c)
  );

  // second row: halve the even sum of the other lane and add the gated multiplicand
  ilv_mont_row #(.W(W)) u_row_mul (
    .x(mid_s >> 1), .y(mid_c), .v(a_r), .g(b_reg),
    .s(l2_s), .c(l2_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_r   <= '0;
      m_r   <= '0;
      cur_s <= '0;
      cur_c <= '0;
      mid_s <= '0;
      mid_c <= '0;
      b_reg <= 1'b0;
    end else if (start) begin
      a_r   <= {2'b00, a_in};
      m_r   <= {2'b00, m_in};
      cur_s <= '0;
      cur_c <= '0;
      mid_s <= '0;
      mid_c <= '0;
      b_reg <= 1'b0;
    end else if (upd) begin
      cur_s <= l2_s;
      cur_c <= l2_c;
      mid_s <= l1_s;
      mid_c <= l1_c;
      b_reg <= bgate & b_in;
    end
  end

  ilv_mont_serout #(.W(W)) u_ser (
    .clk(clk), .rst(rst), .en(load | emit), .load(load),
    .in_s(cur_s), .in_c(cur_c), .bit_o(ser_bit)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      res_valid <= 1'b0;
      res_lane  <= 1'b0;
      res_bit   <= 1'b0;
    end else begin
      res_valid <= emit;
      res_lane  <= emit & lane;
      res_bit   <= emit & ser_bit;
    end
  end
endmodule

// File: rtl/ilv_mont_mul_chk.sv
module ilv_mont_mul_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic res_valid,
  input logic res_lane,
  input logic res_bit,
  input logic upd,
  input logic mid_lsb
);
  // R1: the sum after the modulus row is always even, so halving is exact
  assert_even_before_halve_R1: assert property (@(posedge clk) disable iff (rst)
    upd |-> !mid_lsb);

  // R5: a burst of result bits opens with lane 0
  assert_burst_lane0_first_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> !res_lane);

  // R6: a lane 0 bit is always followed by a lane 1 bit
  assert_lane_alternates_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_lane && !start) |=> (res_valid && res_lane));

  // R7: outputs stay quiet while no bit is valid
  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_bit && !res_lane));

  // R8: a start pulse drops the output stream on the next cycle
  assert_restart_drops_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> !res_valid);
endmodule

bind ilv_mont_mul ilv_mont_mul_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .res_valid(res_valid),
  .res_lane(res_lane), .res_bit(res_bit), .upd(upd), .mid_lsb(mid_s[0])
);

// File: tb/ilv_mont_mul_bench.sv
`timescale 1ns/1ps
module ilv_mont_mul_bench;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          b_in = 1'b0;
  logic [NB-1:0] a_in = '0;
  logic [NB-1:0] m_in = '0;
  logic          res_bit, res_valid, res_lane;

  int total = 0;
  int bad = 0;
  longint got0, got1;
  bit timing_ok, lane_ok;

  always #2.5 clk = ~clk;

  ilv_mont_mul #(.WIDTH(NB)) u_ilv_mont_mul (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .m_in(m_in),
    .b_in(b_in), .res_bit(res_bit), .res_valid(res_valid), .res_lane(res_lane)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mont_ref(input longint a, input longint b, input longint m);
    longint p = 0;
    for (int i = 0; i <= NB; i++) begin
      longint q;
      q = p % 2;
      p = (p + q * m) / 2 + ((i < NB) ? ((b >> i) & 1) : 0) * a;
    end
    return p;
  endfunction

  // called at a negedge; drives start, then runs one full interleaved job
  task automatic run_job(input longint a, input longint m, input longint b0,
                         input longint b1, input bit junk, input bit twiddle,
                         input int stop_at);
    start = 1'b1;
    a_in  = NB'(a);
    m_in  = NB'(m);
    got0 = 0;
    got1 = 0;
    timing_ok = 1'b1;
    lane_ok = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= 4 * NB + 5; j++) begin
      @(negedge clk);
      if (j == 0) start = 1'b0;
      if (twiddle && j == 1) begin
        a_in = ~NB'(a);
        m_in = ~NB'(m);
      end
      if (j < 2 * NB) b_in = (j % 2 == 0) ? 1'((b0 >> (j / 2)) & 1) : 1'((b1 >> (j / 2)) & 1);
      else b_in = junk;
      begin
        bit vexp;
        int idx;
        vexp = (j >= 2 * NB + 4) && (j <= 4 * NB + 3);
        idx = j - (2 * NB + 4);
        if (res_valid !== vexp) timing_ok = 1'b0;
        if (!vexp && (res_bit !== 1'b0 || res_lane !== 1'b0)) timing_ok = 1'b0;
        if (vexp) begin
          if (res_lane !== 1'(idx % 2)) lane_ok = 1'b0;
          if (idx % 2 == 0) got0 = got0 | (longint'(res_bit) << (idx / 2));
          else got1 = got1 | (longint'(res_bit) << (idx / 2));
        end
      end
      if (j == stop_at) return;
    end
  endtask

  task automatic full_checks(input longint a, input longint m, input longint b0, input longint b1);
    longint e0, e1;
    e0 = mont_ref(a, b0, m);
    e1 = mont_ref(a, b1, m);
    check(got0 == e0, "R1 lane0 value", got0, e0);
    check(got1 == e1, "R1 lane1 value", got1, e1);
    check(((got0 << NB) % m) == ((a * b0) % m), "R2 lane0 congruence", (got0 << NB) % m, (a * b0) % m);
    check(((got1 << NB) % m) == ((a * b1) % m), "R2 lane1 congruence", (got1 << NB) % m, (a * b1) % m);
    check(got0 < 2 * m && got1 < 2 * m, "R3 bound", (got0 > got1) ? got0 : got1, 2 * m - 1);
    check(timing_ok, "R5 valid window", 0, 1);
    check(lane_ok, "R6 lane flag", 0, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint mods [5] = '{1, 3, 11, 37, 63};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(res_valid === 1'b0 && res_bit === 1'b0 && res_lane === 1'b0,
            "R7 reset outputs", {res_valid, res_bit, res_lane}, 0);
    end

    foreach (mods[mi]) begin
      longint m, st;
      m = mods[mi];
      st = (m <= 11) ? 1 : ((m <= 37) ? 5 : 7);
      for (longint a = 0; a < 2 * m; a += st) begin
        for (longint b0 = 0; b0 < 2 * m; b0 += st) begin
          longint b1;
          b1 = (2 * m - 1 - b0 + a) % (2 * m);
          run_job(a, m, b0, b1, 1'b0, 1'b0, -1);
          full_checks(a, m, b0, b1);
        end
      end
    end

    // R4: ones on the two trailing input slots change nothing
    run_job(45, 63, 125, 77, 1'b1, 1'b0, -1);
    full_checks(45, 63, 125, 77);
    check(got0 == mont_ref(45, 125, 63) && got1 == mont_ref(45, 77, 63),
          "R4 trailing slots ignored", got0, mont_ref(45, 125, 63));

    // R9: operand inputs flipped after the start edge
    run_job(101, 61, 33, 120, 1'b0, 1'b1, -1);
    full_checks(101, 61, 33, 120);
    check(got0 == mont_ref(101, 33, 61) && got1 == mont_ref(101, 120, 61),
          "R9 operands held", got0, mont_ref(101, 33, 61));

    // R8: restart while the first job's result bits are leaving
    run_job(7, 59, 100, 3, 1'b0, 1'b0, 2 * NB + 7);
    check(res_valid === 1'b1, "R8 first job was emitting", res_valid, 1);
    run_job(90, 47, 12, 93, 1'b0, 1'b0, -1);
    full_checks(90, 47, 12, 93);
    check(timing_ok && got0 == mont_ref(90, 12, 47) && got1 == mont_ref(90, 93, 47),
          "R8 restarted job", got1, mont_ref(90, 93, 47));

    // R7: idle after the last job
    repeat (4) @(negedge clk);
    check(res_valid === 1'b0 && res_bit === 1'b0, "R7 idle outputs", {res_valid, res_bit}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule